// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC. It watches the byte stream of each incoming frame and decides, from the six destination bytes at the head of the frame, whether the frame is for this station. The stream carries one byte per beat, qualified by a valid strobe, with flags for the first and last byte of the frame. The station address is a static 48-bit input. A small mode register holds three acceptance switches: unicast, broadcast and promiscuous. Software loads this register through a write strobe, and it comes out of reset with unicast and broadcast on and promiscuous off.

The decision is presented one cycle after the sixth destination byte has been taken. It then holds, unchanged, until the frame's last byte has gone by. A frame that ends early gets a drop verdict. Group addresses other than broadcast are never matched; only promiscuous mode lets them through. Downstream logic uses the verdict to commit or discard the frame it is buffering.

Top module: `rx_da_filter`

## Requirements
- R1: After reset the mode register holds unicast on, broadcast on and promiscuous off, and `flt_valid`, `flt_accept` and `flt_done` are all low.
- R2: When mode bit 0 (unicast) is set, a frame is accepted if its destination equals `station_addr` and the destination's group bit is clear. When bit 0 is clear, such a frame is dropped unless another mode accepts it.
- R3: When mode bit 1 (broadcast) is set, a destination of all ones is accepted. When bit 1 is clear, that destination is dropped unless promiscuous mode is on.
- R4: When mode bit 2 (promiscuous) is set, every frame of six or more bytes is accepted, whatever its destination.
- R5: A destination whose group bit is set and which is not all ones is dropped unless promiscuous mode is on. The group bit is bit 0 of the first destination byte. Bit 6 of `cfg_word` is reserved and has no effect on any verdict.
- R6: Destination bytes are matched in arrival order. The first byte of the frame is compared with `station_addr[47:40]` and the sixth with `station_addr[7:0]`.
- R7: `flt_valid` rises, with the verdict on `flt_accept`, in the cycle after the clock edge that takes the sixth destination byte.
- R8: The verdict holds until the frame's last byte. `flt_done` is high for exactly one cycle, the cycle after the edge that takes the last byte, and `flt_valid` falls after it unless a new frame has already decided.
- R9: A frame whose last byte comes before its sixth byte yields one cycle with `flt_valid` and `flt_done` high and `flt_accept` low.
- R10: A write to the mode register takes effect for decisions made at later edges. A write on the same edge as the sixth byte does not affect that frame. A verdict already presented does not change when the mode changes.
- R11: Cycles with `in_valid` low are ignored. Bytes that arrive outside a frame, before any start flag, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Loads `cfg_word` into the mode register |
| cfg_word | input | 8 | Mode word: bit 0 unicast, bit 1 broadcast, bit 2 promiscuous, bit 6 reserved |
| station_addr | input | 48 | Station address, first-transmitted byte in bits 47:40 |
| in_valid | input | 1 | A byte is present on `in_data` |
| in_sof | input | 1 | This byte is the first of a frame |
| in_eof | input | 1 | This byte is the last of a frame |
| in_data | input | 8 | Frame byte |
| flt_valid | output | 1 | A verdict is presented |
| flt_accept | output | 1 | The verdict is accept (low when no verdict) |
| flt_done | output | 1 | The frame the verdict belongs to has ended |

## Verification
The assertions assume a start flag never arrives while a frame is still open. The one exception is the cycle right after the last byte, when a new frame may begin. They also assume that a frame's byte count is taken only from beats with `in_valid` high. The stimulus respects both assumptions. It starts each frame either after an idle cycle or directly in the cycle after the previous end, and it puts gaps and stray bytes only where they are legal: gaps inside a frame, stray bytes between frames. Mode writes are placed before a frame, during its address bytes, on the sixth byte and during the payload, so that the reference model can check the rule on which edge a write takes effect.

// File: rtl/rx_da_filter_pkg.sv
package rx_da_filter_pkg;

    localparam int MODE_UC_BIT = 0;
    localparam int MODE_BC_BIT = 1;
    localparam int MODE_PR_BIT = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_HOLD = 2'd2,
        ST_DONE = 2'd3
    } flt_state_e;

    typedef struct packed {
        logic uc;
        logic bc;
        logic pr;
    } flt_mode_t;

    localparam flt_mode_t MODE_RESET = '{uc: 1'b1, bc: 1'b1, pr: 1'b0};

endpackage

// File: rtl/rx_da_filter_mode.sv
module rx_da_filter_mode
    import rx_da_filter_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] word,
    output flt_mode_t        mode
);
    flt_mode_t mode_d, mode_q;
    logic      cfg_unused;

    // Only the three switch bits are stored; the rest of the word is dropped.
    assign cfg_unused = ^word;

    always_comb begin
        mode_d = mode_q;
        if (we) begin
            mode_d.uc = word[MODE_UC_BIT];
            mode_d.bc = word[MODE_BC_BIT];
            mode_d.pr = word[MODE_PR_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_RESET;
        else        mode_q <= mode_d;
    end

    assign mode = mode_q;
endmodule

// File: rtl/rx_da_filter_cmp.sv
module rx_da_filter_cmp #(
    parameter int ADDR_BYTES = 6,
    parameter int BYTE_W     = 8,
    parameter int IDX_W      = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         step,
    input  logic [IDX_W-1:0]             idx,
    input  logic [BYTE_W-1:0]            data,
    input  logic [ADDR_BYTES*BYTE_W-1:0] station,
    output logic                         match_now,
    output logic                         ones_now,
    output logic                         group_now
);
    typedef struct packed {
        logic match;
        logic ones;
        logic group;
    } cmp_t;

    cmp_t              cmp_d, cmp_q;
    logic [BYTE_W-1:0] sta_byte [ADDR_BYTES];
    logic [BYTE_W-1:0] sel;

    // Byte 0 is the first on the wire and sits in the top bits.
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_split
        assign sta_byte[g] = station[(ADDR_BYTES-1-g)*BYTE_W +: BYTE_W];
    end

    always_comb begin
        sel = '0;
        for (int i = 0; i < ADDR_BYTES; i++) begin
            if (idx == IDX_W'(i)) sel = sta_byte[i];
        end
        match_now = (start ? 1'b1 : cmp_q.match) & (data == sel);
        ones_now  = (start ? 1'b1 : cmp_q.ones) & (&data);
        group_now = start ? data[0] : cmp_q.group;
        cmp_d = cmp_q;
        if (step) begin
            cmp_d.match = match_now;
            cmp_d.ones  = ones_now;
            cmp_d.group = group_now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cmp_q <= '0;
        else        cmp_q <= cmp_d;
    end
endmodule

// File: rtl/rx_da_filter_decide.sv
module rx_da_filter_decide
    import rx_da_filter_pkg::*;
(
    input  flt_mode_t mode,
    input  logic      match,
    input  logic      ones,
    input  logic      group,
    output logic      accept
);
    always_comb begin
        accept = mode.pr
               | (mode.bc & ones)
               | (mode.uc & match & ~group);
    end
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
    import rx_da_filter_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int BYTE_W     = 8,
    parameter int CFG_W      = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [CFG_W-1:0]             cfg_word,
    input  logic [ADDR_BYTES*BYTE_W-1:0] station_addr,
    input  logic                         in_valid,
    input  logic                         in_sof,
    input  logic                         in_eof,
    input  logic [BYTE_W-1:0]            in_data,
    output logic                         flt_valid,
    output logic                         flt_accept,
    output logic                         flt_done
);
    localparam int IDX_W = $clog2(ADDR_BYTES + 1);

    typedef struct packed {
        flt_state_e       st;
        logic [IDX_W-1:0] cnt;
        logic             acc;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    flt_mode_t        mode;
    logic             first, cont, addr_beat, last;
    logic [IDX_W-1:0] idx;
    logic             match_now, ones_now, group_now, acc_now;

    rx_da_filter_mode #(.CFG_W(CFG_W)) u_mode (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (cfg_we),
        .word (cfg_word),
        .mode (mode)
    );

    rx_da_filter_cmp #(
        .ADDR_BYTES(ADDR_BYTES),
        .BYTE_W    (BYTE_W),
        .IDX_W     (IDX_W)
    ) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (first),
        .step     (addr_beat),
        .idx      (idx),
        .data     (in_data),
        .station  (station_addr),
        .match_now(match_now),
        .ones_now (ones_now),
        .group_now(group_now)
    );

    rx_da_filter_decide u_decide (
        .mode  (mode),
        .match (match_now),
        .ones  (ones_now),
        .group (group_now),
        .accept(acc_now)
    );

    always_comb begin
        first     = in_valid & in_sof;
        cont      = in_valid & ~in_sof & (ctl_q.st == ST_ADDR);
        addr_beat = first | cont;
        idx       = first ? '0 : ctl_q.cnt;
        last      = addr_beat & (idx == IDX_W'(ADDR_BYTES - 1));

        ctl_d = ctl_q;
        if (ctl_q.st == ST_DONE) ctl_d.st = ST_IDLE;
        if (addr_beat) begin
            ctl_d.cnt = idx + 1'b1;
            if (last) begin
                ctl_d.acc = acc_now;
                ctl_d.st  = in_eof ? ST_DONE : ST_HOLD;
            end else if (in_eof) begin
                ctl_d.acc = 1'b0;
                ctl_d.st  = ST_DONE;
            end else begin
                ctl_d.st  = ST_ADDR;
            end
        end else if (in_valid && in_eof && ctl_q.st == ST_HOLD) begin
            ctl_d.st = ST_DONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, cnt: '0, acc: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign flt_valid  = (ctl_q.st == ST_HOLD) | (ctl_q.st == ST_DONE);
    assign flt_accept = flt_valid & ctl_q.acc;
    assign flt_done   = (ctl_q.st == ST_DONE);
endmodule

// File: rtl/rx_da_filter_chk.sv
module rx_da_filter_chk #(
    parameter int ADDR_BYTES = 6
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_sof,
    input logic in_eof,
    input logic flt_valid,
    input logic flt_accept,
    input logic flt_done
);
    localparam int CW = $clog2(ADDR_BYTES + 2);

    logic [CW-1:0] cnt_q, cnt_now;
    logic          open_q, open_now;

    always_comb begin
        open_now = in_sof | open_q;
        if (in_sof)                             cnt_now = CW'(1);
        else if (cnt_q == CW'(ADDR_BYTES + 1))  cnt_now = cnt_q;
        else                                    cnt_now = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            open_q <= 1'b0;
        end else if (in_valid && open_now) begin
            cnt_q  <= cnt_now;
            open_q <= ~in_eof;
        end
    end

    AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        flt_accept |-> flt_valid);                                            // R2
    AST_SIXTH_DECIDES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && open_now && cnt_now == CW'(ADDR_BYTES)) |=> flt_valid);  // R7
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_done && !in_valid) |=> !flt_valid);                              // R8
    AST_DONE_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        flt_done |-> flt_valid);                                              // R8
    AST_SHORT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && open_now && in_eof && cnt_now < CW'(ADDR_BYTES))
        |=> (flt_done && !flt_accept));                                       // R9
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && !flt_done && !(in_valid && in_sof))
        |=> (flt_valid && $stable(flt_accept)));                              // R10
    AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flt_valid) |-> $past(in_valid));                                // R11
endmodule

bind rx_da_filter rx_da_filter_chk #(.ADDR_BYTES(ADDR_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_eof    (in_eof),
    .flt_valid (flt_valid),
    .flt_accept(flt_accept),
    .flt_done  (flt_done)
);

// File: tb/rx_da_filter_tb.sv
module rx_da_filter_tb;
    localparam logic [47:0] STA   = 48'h021A_3C4D_5E6F;
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] MCAST = 48'h0100_5E00_0001;
    localparam logic [47:0] OTHER = 48'h021A_3C4D_5E70;
    localparam logic [47:0] REVSD = 48'h6F5E_4D3C_1A02;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_word = 8'h00;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        flt_valid, flt_accept, flt_done;

    int    vectors = 0;
    int    misses  = 0;
    int    cycles  = 0;
    string cur_req = "R1";

    // reference model state
    byte unsigned q[$];
    bit in_frame = 0, decided = 0;
    bit m_uc = 1, m_bc = 1, m_pr = 0;
    bit exp_valid = 0, exp_accept = 0, exp_done = 0;

    always #2 clk = ~clk;

    rx_da_filter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
        .station_addr(STA), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_data(in_data), .flt_valid(flt_valid),
        .flt_accept(flt_accept), .flt_done(flt_done)
    );

    function automatic bit model_decide();
        logic [47:0] d = '0;
        for (int i = 0; i < 6; i++) d = {d[39:0], 8'(q[i])};
        return m_pr | (m_bc && d == BCAST) | (m_uc && d == STA && !d[40]);
    endfunction

    always @(posedge clk) begin
        bit nv, na, nd;
        cycles++;
        if (!rst_n) begin
            q.delete(); in_frame = 0; decided = 0;
            m_uc = 1; m_bc = 1; m_pr = 0;
            exp_valid = 0; exp_accept = 0; exp_done = 0;
        end else begin
            nv = 0; na = 0; nd = 0;
            if (exp_valid && !exp_done) begin nv = 1; na = exp_accept; end
            if (in_valid) begin
                if (in_sof) begin
                    q.delete(); in_frame = 1; decided = 0; nv = 0; na = 0;
                end
                if (in_frame) begin
                    if (!decided) begin
                        q.push_back(in_data);
                        if (q.size() == 6) begin
                            decided = 1; nv = 1; na = model_decide();
                        end
                    end
                    if (in_eof) begin
                        in_frame = 0;
                        if (!decided) begin nv = 1; na = 0; end
                        nd = 1;
                    end
                end
            end
            if (cfg_we) begin m_uc = cfg_word[0]; m_bc = cfg_word[1]; m_pr = cfg_word[2]; end
            exp_valid = nv; exp_accept = na; exp_done = nd;
        end
        #1;
        vectors++;
        if (flt_valid !== exp_valid || flt_accept !== exp_accept || flt_done !== exp_done) begin
            misses++;
            $display("FAIL %s valid/accept/done actual=%b%b%b expected=%b%b%b at cycle %0d",
                     cur_req, flt_valid, flt_accept, flt_done,
                     exp_valid, exp_accept, exp_done, cycles);
        end
    end

    always @(posedge clk) begin
        if (cycles > 50000) begin
            misses++;
            $display("FAIL watchdog actual=%0d cycles expected=under 50000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 0; in_sof = 0; in_eof = 0; cfg_we = 0;
        end
    endtask

    task automatic set_mode(input logic [7:0] v);
        @(negedge clk);
        in_valid = 0; cfg_we = 1; cfg_word = v;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic send_frame(input logic [47:0] da, input int len, input int gap_at,
                              input int wr_at, input logic [7:0] wr_val, input bit tail);
        for (int i = 0; i < len; i++) begin
            if (i == gap_at) begin
                @(negedge clk);
                in_valid = 0; in_sof = 0; in_eof = 0; cfg_we = 0;
            end
            @(negedge clk);
            in_valid = 1; in_sof = (i == 0); in_eof = (i == len - 1);
            in_data  = (i < 6) ? da[47-8*i -: 8] : 8'(i * 37);
            cfg_we   = (i == wr_at); cfg_word = wr_val;
        end
        if (tail) idle(1);
    endtask

    initial begin
        idle(3);
        cur_req = "R1";                       // reset state checked every cycle
        rst_n = 1;
        idle(2);
        cur_req = "R1";                       // default modes: unicast and broadcast on
        send_frame(STA, 10, -1, -1, 0, 1);
        send_frame(BCAST, 8, -1, -1, 0, 1);
        send_frame(MCAST, 8, -1, -1, 0, 1);

        cur_req = "R2";
        send_frame(OTHER, 9, -1, -1, 0, 1);
        set_mode(8'h02);
        send_frame(STA, 9, -1, -1, 0, 1);
        set_mode(8'h01);
        send_frame(STA, 9, -1, -1, 0, 1);

        cur_req = "R3";
        send_frame(BCAST, 7, -1, -1, 0, 1);
        set_mode(8'h03);
        send_frame(BCAST, 7, -1, -1, 0, 1);

        cur_req = "R4";
        set_mode(8'h04);
        send_frame(OTHER, 8, -1, -1, 0, 1);
        send_frame(MCAST, 8, -1, -1, 0, 1);
        send_frame(48'h0, 6, -1, -1, 0, 1);

        cur_req = "R5";
        set_mode(8'h43);
        send_frame(MCAST, 8, -1, -1, 0, 1);
        set_mode(8'h40);
        send_frame(BCAST, 8, -1, -1, 0, 1);
        send_frame(STA, 8, -1, -1, 0, 1);

        cur_req = "R6";
        set_mode(8'h01);
        send_frame(REVSD, 8, -1, -1, 0, 1);
        send_frame(48'h021A_3C4D_5E6E, 8, -1, -1, 0, 1);

        cur_req = "R7";
        set_mode(8'h03);
        send_frame(STA, 6, -1, -1, 0, 1);      // end on the sixth byte
        send_frame(BCAST, 6, -1, -1, 0, 1);

        cur_req = "R8";
        send_frame(STA, 30, -1, -1, 0, 1);
        send_frame(STA, 12, -1, -1, 0, 0);     // next frame starts right after the end
        send_frame(BCAST, 10, -1, -1, 0, 0);
        send_frame(OTHER, 10, -1, -1, 0, 1);

        cur_req = "R9";
        send_frame(STA, 1, -1, -1, 0, 1);
        send_frame(STA, 3, -1, -1, 0, 1);
        send_frame(BCAST, 5, -1, -1, 0, 1);
        set_mode(8'h07);
        send_frame(BCAST, 5, -1, -1, 0, 1);

        cur_req = "R10";
        set_mode(8'h01);
        send_frame(STA, 14, -1, 9, 8'h00, 1);  // unicast off after decision
        send_frame(STA, 14, -1, 5, 8'h00, 1);  // write with the sixth byte
        send_frame(STA, 14, -1, 3, 8'h01, 1);  // write during address bytes
        send_frame(OTHER, 14, -1, 8, 8'h04, 1);
        send_frame(OTHER, 8, -1, -1, 0, 1);

        cur_req = "R11";
        set_mode(8'h03);
        send_frame(STA, 12, 3, -1, 0, 1);      // gap inside address bytes
        send_frame(STA, 12, 8, -1, 0, 1);      // gap inside payload
        for (int i = 0; i < 5; i++) begin      // stray bytes with no start flag
            @(negedge clk);
            in_valid = 1; in_sof = 0; in_eof = (i == 4); in_data = 8'hFF;
        end
        idle(3);
        send_frame(BCAST, 7, 5, -1, 0, 1);

        idle(4);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule